// File: doc/BRIEF.md
# Serial Stream Timestamp Capture Unit

This block attaches time tags to two asynchronous character streams and to a once-per-second pulse. One stream comes from a satellite positioning receiver and the other from an inertial sensor. One free-running tick counter is the shared time base. A prescaler advances it once every `TICK_DIV` clock cycles. At 125 MHz the default gives one count per 5.12 ms.

Each of the three inputs passes through a two-flop synchroniser. The pulse input is then watched for rising edges. Each receive line is watched for the falling edge that starts a character frame. When an edge is detected, the current count is copied into a holding slot for that source.

A receive line is armed again only after it has stayed high for a full character time. This keeps the data bits inside a frame from producing more tags.

Pending tags leave through one valid/ready port. Each tag carries a 2-bit source code and the count value. When more than one tag is waiting, a fixed priority decides which goes out first. Each source also has a sticky overrun flag, which shows that a tag was overwritten before the host accepted it.

Top module: `stamp_capture_top`

## Requirements
- R1: After reset the time base reads zero. It advances by exactly one every `TICK_DIV` clock cycles and wraps modulo 2^`COUNT_W`. The count captured for an event is the value the time base holds in the cycle after the second synchroniser flop has taken the new input level.
- R2: A rising edge on `pps_i` produces exactly one capture with source code 00, however long the input stays high. If the input changes before rising clock edge k, the stamp holds the count present between edges k+1 and k+2, and `valid_o` goes high after edge k+2.
- R3: A falling edge on `gps_rx_i` produces a capture with source code 01, and a falling edge on `imu_rx_i` produces one with source code 10. Latency and stamp value follow the same rule as R2.
- R4: After a receive-line capture, later falling edges on that line are ignored until the synchronised line has been high for at least `BIT_CYCLES*CHAR_BITS` consecutive clock cycles. A full character with several internal high-to-low transitions therefore yields exactly one stamp.
- R5: `valid_o` is high whenever any source has a pending stamp. It stays high until accepted. A stamp is removed at a rising clock edge where both `valid_o` and `ready_i` are high.
- R6: When several sources are pending, the output offers them in this order: pulse (00) first, then positioning stream (01), then inertial stream (10). Code 11 never appears while `valid_o` is high.
- R7: A capture on a source whose previous stamp is still pending sets that source's bit in `overrun_o` (bit 0 pulse, bit 1 positioning, bit 2 inertial). The newer stamp replaces the older one. An overrun bit stays set until reset.
- R8: With a narrow `COUNT_W`, captured stamps equal the tick count modulo 2^`COUNT_W`.
- R9: Reset clears the time base, the prescaler, every pending stamp and every overrun bit. Reset therefore drives `valid_o` and `overrun_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pps_i | input | 1 | Once-per-second pulse, asynchronous |
| gps_rx_i | input | 1 | Positioning receiver serial line, idle high, asynchronous |
| imu_rx_i | input | 1 | Inertial sensor serial line, idle high, asynchronous |
| ready_i | input | 1 | Host accepts the offered stamp |
| valid_o | output | 1 | A stamp is offered |
| src_o | output | 2 | Source of the offered stamp (00 pulse, 01 positioning, 10 inertial) |
| stamp_o | output | COUNT_W | Captured tick count |
| overrun_o | output | 3 | Sticky per-source overrun flags |

## Verification
An input changed at a falling clock edge is taken by the first synchroniser flop at the next rising edge and reaches the second flop one edge later. The slot captures it at the third rising edge. The bench therefore expects `valid_o` high at the third falling edge after the drive, and low at the second. The expected stamp is the bench's own count of rising edges since reset, plus two, divided by `TICK_DIV`. Re-arm windows are driven to exactly one cycle short of the character time and to exactly the character time. Every check samples at a falling edge, after the registers on the path have settled.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned SRC_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_PPS = 2'b00,
    SRC_GPS = 2'b01,
    SRC_IMU = 2'b10
  } src_e;
endpackage

// File: rtl/stamp_timebase.sv
module stamp_timebase #(
  parameter int unsigned COUNT_W  = 32,
  parameter int unsigned TICK_DIV = 640000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [COUNT_W-1:0] count_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [COUNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      count_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q   <= '0;
      count_q <= count_q + 1'b1;
    end else begin
      pre_q   <= pre_q + 1'b1;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/stamp_edge_det.sv
module stamp_edge_det #(
  parameter bit          IDLE       = 1'b1,
  parameter int unsigned ARM_CYCLES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic pulse_o
);
  logic s1_q, s2_q, s3_q;
  logic raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= IDLE;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // edge away from the idle level
  assign raw = IDLE ? (s3_q & ~s2_q) : (~s3_q & s2_q);

  generate
    if (ARM_CYCLES == 0) begin : g_free
      assign pulse_o = raw;
    end else begin : g_arm
      localparam int unsigned RUN_W = $clog2(ARM_CYCLES + 1);
      localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ARM_CYCLES - 1);

      logic             armed_q;
      logic [RUN_W-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          armed_q <= 1'b1;
          run_q   <= '0;
        end else if (raw && armed_q) begin
          armed_q <= 1'b0;
          run_q   <= '0;
        end else if (!armed_q) begin
          if (s2_q == IDLE) begin
            run_q <= run_q + 1'b1;
            if (run_q == RUN_LAST) armed_q <= 1'b1;
          end else begin
            run_q <= '0;
          end
        end
      end

      assign pulse_o = raw & armed_q;
    end
  endgenerate
endmodule

// File: rtl/stamp_slot.sv
module stamp_slot #(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               take_i,
  output logic               pend_o,
  output logic [COUNT_W-1:0] stamp_o,
  output logic               ovr_o
);
  logic               pend_q, ovr_q;
  logic [COUNT_W-1:0] stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      ovr_q   <= 1'b0;
      stamp_q <= '0;
    end else if (cap_i) begin
      stamp_q <= count_i;
      pend_q  <= 1'b1;
      // old stamp lost unless it leaves in this same cycle
      if (pend_q && !take_i) ovr_q <= 1'b1;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o  = pend_q;
  assign stamp_o = stamp_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/stamp_capture_top.sv
module stamp_capture_top
  import stamp_pkg::*;
#(
  parameter int unsigned COUNT_W    = 32,
  parameter int unsigned TICK_DIV   = 640000,
  parameter int unsigned BIT_CYCLES = 1085,
  parameter int unsigned CHAR_BITS  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pps_i,
  input  logic               gps_rx_i,
  input  logic               imu_rx_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [1:0]         src_o,
  output logic [COUNT_W-1:0] stamp_o,
  output logic [2:0]         overrun_o
);
  localparam int unsigned FRAME_CYCLES = BIT_CYCLES * CHAR_BITS;

  logic [COUNT_W-1:0] count_q;
  logic [NSRC-1:0]    lines, cap, pend, take, ovr;
  logic [COUNT_W-1:0] stamps [NSRC];
  logic               found;
  logic [SRC_W-1:0]   sel;
  logic [COUNT_W-1:0] sel_stamp;

  assign lines = {imu_rx_i, gps_rx_i, pps_i};

  stamp_timebase #(
    .COUNT_W (COUNT_W),
    .TICK_DIV(TICK_DIV)
  ) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .count_o(count_q)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // source 0 is the pulse: rising edge, no re-arm window
    stamp_edge_det #(
      .IDLE      ((i == 0) ? 1'b0 : 1'b1),
      .ARM_CYCLES((i == 0) ? 0 : FRAME_CYCLES)
    ) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (lines[i]),
      .pulse_o(cap[i])
    );

    stamp_slot #(
      .COUNT_W(COUNT_W)
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap[i]),
      .count_i(count_q),
      .take_i (take[i]),
      .pend_o (pend[i]),
      .stamp_o(stamps[i]),
      .ovr_o  (ovr[i])
    );
  end

  // lowest index wins
  always_comb begin
    found     = 1'b0;
    sel       = '0;
    sel_stamp = '0;
    take      = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && !found) begin
        found     = 1'b1;
        sel       = SRC_W'(i);
        sel_stamp = stamps[i];
        take[i]   = ready_i;
      end
    end
  end

  assign valid_o   = found;
  assign src_o     = sel;
  assign stamp_o   = sel_stamp;
  assign overrun_o = ovr;
endmodule

// File: rtl/stamp_capture_chk.sv
module stamp_capture_chk #(
  parameter int unsigned COUNT_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_o,
  input logic               ready_i,
  input logic [1:0]         src_o,
  input logic [2:0]         overrun_o,
  input logic [COUNT_W-1:0] count_i
);
  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != $past(count_i)) |-> (count_i == COUNT_W'($past(count_i) + 1'b1)));

  // R5
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o);

  // R6
  src_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (src_o != 2'b11));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(overrun_o) & ~overrun_o) == 3'b000));
endmodule

bind stamp_capture_top stamp_capture_chk #(
  .COUNT_W(COUNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_o  (valid_o),
  .ready_i  (ready_i),
  .src_o    (src_o),
  .overrun_o(overrun_o),
  .count_i  (count_q)
);

// File: tb/stamp_capture_top_tb.sv
module stamp_capture_top_tb;
  import stamp_pkg::*;

  localparam int unsigned TD    = 8;
  localparam int unsigned BITC  = 4;
  localparam int unsigned NCHAR = 10;
  localparam int unsigned FRAME = BITC * NCHAR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pps = 1'b0, gps = 1'b1, imu = 1'b1, rdy = 1'b0, pps_w = 1'b0;
  logic        valid, valid_w;
  logic [1:0]  src, src_w;
  logic [31:0] stamp;
  logic [3:0]  stamp_w;
  logic [2:0]  ovr, ovr_w;
  int unsigned cyc;
  int vectors = 0, fails = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  stamp_capture_top #(.COUNT_W(32), .TICK_DIV(TD), .BIT_CYCLES(BITC), .CHAR_BITS(NCHAR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .gps_rx_i(gps), .imu_rx_i(imu),
    .ready_i(rdy), .valid_o(valid), .src_o(src), .stamp_o(stamp), .overrun_o(ovr));

  stamp_capture_top #(.COUNT_W(4), .TICK_DIV(2), .BIT_CYCLES(BITC), .CHAR_BITS(NCHAR)) u_wrap (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps_w), .gps_rx_i(1'b1), .imu_rx_i(1'b1),
    .ready_i(1'b1), .valid_o(valid_w), .src_o(src_w), .stamp_o(stamp_w), .overrun_o(ovr_w));

  function automatic logic [31:0] ex(input int unsigned n);
    return 32'((n + 2) / TD);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pop(input string req, input logic [1:0] es, input logic [31:0] et);
    chk({req, " valid"}, 64'(valid), 64'd1);
    chk({req, " src"}, 64'(src), 64'(es));
    chk({req, " stamp"}, 64'(stamp), 64'(et));
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
  endtask

  task automatic fire(input int s, output logic [31:0] e);
    e = ex(cyc);
    case (s)
      0: pps = 1'b1;
      1: gps = 1'b0;
      default: imu = 1'b0;
    endcase
    repeat (BITC) @(negedge clk);
    pps = 1'b0; gps = 1'b1; imu = 1'b1;
  endtask

  task automatic send_char(input logic [7:0] b, output logic [31:0] e);
    e = ex(cyc);
    gps = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      gps = b[k];
      repeat (BITC) @(negedge clk);
    end
    gps = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  initial begin
    logic [31:0] e, e1, e2, e3;
    int unsigned n;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset valid", 64'(valid), 64'd0);
    chk("R9 reset overrun", 64'(ovr), 64'd0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);

    // R2 latency and single capture on a long pulse
    n = cyc; pps = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not yet valid", 64'(valid), 64'd0);
    @(negedge clk);
    chk("R2 valid at third edge", 64'(valid), 64'd1);
    repeat (7) @(negedge clk);
    pps = 1'b0;
    repeat (3) @(negedge clk);
    pop("R2 pps R1", SRC_PPS, ex(n));
    chk("R2 one capture per pulse", 64'(valid), 64'd0);

    // R3 and R4: whole character gives one stamp
    repeat (FRAME + 5) @(negedge clk);
    send_char(8'h55, e);
    pop("R3 gps char", SRC_GPS, e);
    chk("R4 no stamps from data bits", 64'(valid), 64'd0);

    // R4 boundary on the inertial line
    repeat (FRAME + 5) @(negedge clk);
    fire(2, e1);
    repeat (FRAME - 1) @(negedge clk);
    imu = 1'b0;
    repeat (4) @(negedge clk);
    imu = 1'b1;
    pop("R3 imu", SRC_IMU, e1);
    chk("R4 short idle ignored", 64'(valid), 64'd0);
    repeat (FRAME - 1) @(negedge clk);
    fire(2, e2);
    repeat (2) @(negedge clk);
    pop("R4 full idle rearms", SRC_IMU, e2);

    // R6 priority
    repeat (FRAME + 5) @(negedge clk);
    e3 = ex(cyc); imu = 1'b0;
    @(negedge clk);
    e2 = ex(cyc); gps = 1'b0;
    @(negedge clk);
    e1 = ex(cyc); pps = 1'b1;
    repeat (4) @(negedge clk);
    pps = 1'b0; gps = 1'b1; imu = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no overrun yet", 64'(ovr), 64'd0);
    pop("R6 first pps", SRC_PPS, e1);
    pop("R6 then gps", SRC_GPS, e2);
    pop("R6 then imu", SRC_IMU, e3);
    chk("R5 empty after drain", 64'(valid), 64'd0);

    // R7 overrun
    fire(0, e1);
    repeat (2) @(negedge clk);
    fire(0, e2);
    repeat (2) @(negedge clk);
    chk("R7 overrun set", 64'(ovr), 64'd1);
    pop("R7 newest kept", SRC_PPS, e2);
    chk("R7 single entry", 64'(valid), 64'd0);
    chk("R7 sticky", 64'(ovr), 64'd1);

    // R8 wrap on narrow instance
    for (int j = 0; j < 6; j++) begin
      repeat (7 + j) @(negedge clk);
      n = cyc; pps_w = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 wrap valid", 64'(valid_w), 64'd1);
      chk("R8 wrapped stamp", 64'(stamp_w), 64'(4'((n + 2) / 2)));
      pps_w = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R1 R2 R3 random events
    for (int k = 0; k < 40; k++) begin
      int s;
      s = int'($urandom_range(2, 0));
      repeat ($urandom_range(80, FRAME + 5)) @(negedge clk);
      fire(s, e);
      repeat (2) @(negedge clk);
      pop((s == 0) ? "R2 R1 random" : "R3 R1 random", 2'(s), e);
      chk("R5 drained random", 64'(valid), 64'd0);
    end

    // R9 reset mid-run
    fire(0, e);
    chk("R9 pending before reset", 64'(valid), 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears valid", 64'(valid), 64'd0);
    chk("R9 reset clears overrun", 64'(ovr), 64'd0);
    rst_n = 1'b1;
    repeat (21) @(negedge clk);
    fire(0, e);
    pop("R9 R1 count restarts", SRC_PPS, e);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL all watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule